// File: doc/BRIEF.md
# Interrupt and Trap State-Swap Unit

This block owns the machine state word of a processor core: an interrupt-enable bit, a memory-protection enable, a privilege-mode bit and a 16-bit instruction counter. At each instruction boundary it decides whether the core keeps running or enters a handler. A handler can be entered for a pending device interrupt or for a supervisor-call trap. Entry is a single-cycle swap. The running word is written to a reserved save slot, and a handler word takes its place in the same clock edge. The handler word has privileged mode on, interrupts masked, protection off and the counter pointing at the handler.

Devices raise a sticky request flag together with a 4-bit device code. The flag stays set until software pulses an acknowledge. When an interrupt is taken, the device code is copied into a cause register that software can read. A trap carries a 4-bit request code that indexes a 16-entry table of handler addresses; the table is loaded through a write port. A return strobe copies the save slot back into the running word. After reset the save slot holds a user-mode start word, so the first return launches user code with interrupts enabled and protection on.

Top module: `trap_swap_unit`

## Requirements
- R1: After reset the running word has privileged mode 1, interrupt enable 0, protection 0 and counter 0. The save slot holds the user start word (interrupt enable 1, protection 1, privileged 0, counter USER_IC = 0x4000), the request flag is 0, the cause code is 0 and the save strobe is 0.
- R2: An interrupt is entered only on a clock edge where the boundary pulse is high, the request flag is set and interrupt enable is 1. Otherwise the running word is left unchanged, and a masked request waits until a return re-enables interrupts.
- R3: On any entry the running word becomes, at that edge, privileged 1, interrupt enable 0 and protection 0. For an interrupt the counter becomes IRQ_VEC = 0x0100.
- R4: On any entry the pre-entry word is written to the save slot at the same edge, and the save strobe is high for exactly that one cycle. The save port is packed as bit 18 interrupt enable, bit 17 protection, bit 16 privileged, and bits 15:0 the counter.
- R5: A set pulse raises the request flag and records its device code. The flag stays set until an acknowledge pulse clears it. A set and an acknowledge in the same cycle leave the flag set.
- R6: On interrupt entry the recorded device code is copied to the cause output, which holds it until the next interrupt entry.
- R7: A trap strobe together with the boundary pulse enters with the counter loaded from table entry [trap code]. A trap strobe without the boundary pulse has no effect.
- R8: When a trap and an enabled pending interrupt meet at the same boundary, the trap is entered. The request flag stays set.
- R9: A return strobe loads the running word from the save slot at the next edge. A return takes precedence over any entry in the same cycle.
- R10: A table write with address a and data d replaces entry a. Later traps with code a load d.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| instrDone | input | 1 | Instruction boundary pulse |
| trapReq | input | 1 | Supervisor-call strobe |
| trapCode | input | 4 | Trap request code (table index) |
| retStrobe | input | 1 | Return from handler |
| devSet | input | 1 | Device request set pulse |
| devCode | input | 4 | Code of the requesting device |
| devAck | input | 1 | Software acknowledge, clears the flag |
| tblWe | input | 1 | Trap table write enable |
| tblAddr | input | 4 | Trap table write address |
| tblData | input | 16 | Trap table write data |
| curIntEn | output | 1 | Running interrupt enable |
| curProtEn | output | 1 | Running memory protection enable |
| curPriv | output | 1 | Running privilege mode |
| curIc | output | 16 | Running instruction counter |
| saveEn | output | 1 | Save slot written this cycle |
| saveWord | output | 19 | Save slot contents |
| irqFlag | output | 1 | Request flag seen by the core |
| causeCode | output | 4 | Device code latched at interrupt entry |

## Verification
The swap is exercised with a boundary pulse on its own, a trap without a boundary, a trap at a boundary, and a pending interrupt with interrupts enabled and with them masked. These cases separate the decision to enter from the decision to stay put. Combined patterns follow. A trap and an interrupt arrive together to show the ordering. A return and a boundary arrive together to show that return wins. A set and an acknowledge arrive together to show that set wins. Save-port contents and the one-cycle strobe are compared against the pre-entry word, and a table rewrite followed by a trap shows that the address comes from the table rather than from a constant.

// File: rtl/swap_pkg.sv
package swap_pkg;
  localparam int IC_W = 16;

  typedef struct packed {
    logic            intEn;
    logic            protEn;
    logic            privMode;
    logic [IC_W-1:0] icount;
  } stateWord_t;

  localparam int WORD_W = $bits(stateWord_t);

  // strobes from control to datapath
  typedef struct packed {
    logic saveOld;
    logic enterTrap;
    logic enterIrq;
    logic restore;
  } swapCtl_t;
endpackage

// File: rtl/swap_ctrl.sv
module swap_ctrl
  import swap_pkg::*;
(
  input  logic     clk,
  input  logic     rstN,
  input  logic     instrDone,
  input  logic     trapReq,
  input  logic     retStrobe,
  input  logic     irqPending,
  input  logic     intEnabled,
  output swapCtl_t ctl
);
  always_comb begin
    ctl = '0;
    if (retStrobe) begin
      ctl.restore = 1'b1;
    end else if (instrDone) begin
      if (trapReq) begin
        ctl.enterTrap = 1'b1;
        ctl.saveOld   = 1'b1;
      end else if (irqPending && intEnabled) begin
        ctl.enterIrq = 1'b1;
        ctl.saveOld  = 1'b1;
      end
    end
  end

  // R8: at most one action per cycle
  assert_single_action_R8: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({ctl.enterTrap, ctl.enterIrq, ctl.restore}));
endmodule

// File: rtl/swap_datapath.sv
module swap_datapath
  import swap_pkg::*;
#(
  parameter int TRAP_W = 4,
  parameter int DEV_W  = 4,
  parameter logic [IC_W-1:0] IRQ_VEC = 16'h0100,
  parameter logic [IC_W-1:0] USER_IC = 16'h4000
) (
  input  logic              clk,
  input  logic              rstN,
  input  swapCtl_t          ctl,
  input  logic [TRAP_W-1:0] trapCode,
  input  logic              devSet,
  input  logic [DEV_W-1:0]  devCode,
  input  logic              devAck,
  input  logic              tblWe,
  input  logic [TRAP_W-1:0] tblAddr,
  input  logic [IC_W-1:0]   tblData,
  output stateWord_t        curWord,
  output stateWord_t        savedWord,
  output logic              saveStrobe,
  output logic              irqFlagQ,
  output logic [DEV_W-1:0]  causeQ
);
  localparam int TBL_DEPTH = 1 << TRAP_W;

  localparam stateWord_t RESET_WORD = '{intEn: 1'b0, protEn: 1'b0, privMode: 1'b1, icount: '0};
  localparam stateWord_t USER_WORD  = '{intEn: 1'b1, protEn: 1'b1, privMode: 1'b0, icount: USER_IC};

  logic [IC_W-1:0]  trapTable [TBL_DEPTH];
  logic [DEV_W-1:0] pendCode;
  stateWord_t       handlerWord;

  // handler address table, one register per entry
  for (genvar g = 0; g < TBL_DEPTH; g++) begin : gTbl
    always_ff @(posedge clk) begin
      if (!rstN)
        trapTable[g] <= '0;
      else if (tblWe && (tblAddr == TRAP_W'(g)))
        trapTable[g] <= tblData;
    end
  end

  always_comb begin
    handlerWord.intEn    = 1'b0;
    handlerWord.protEn   = 1'b0;
    handlerWord.privMode = 1'b1;
    handlerWord.icount   = ctl.enterTrap ? trapTable[trapCode] : IRQ_VEC;
  end

  // running word and save slot: swapped in one edge
  always_ff @(posedge clk) begin
    if (!rstN) begin
      curWord    <= RESET_WORD;
      savedWord  <= USER_WORD;
      saveStrobe <= 1'b0;
    end else begin
      saveStrobe <= ctl.saveOld;
      if (ctl.restore)
        curWord <= savedWord;
      else if (ctl.enterTrap || ctl.enterIrq) begin
        savedWord <= curWord;
        curWord   <= handlerWord;
      end
    end
  end

  // sticky device request
  always_ff @(posedge clk) begin
    if (!rstN) begin
      irqFlagQ <= 1'b0;
      pendCode <= '0;
    end else if (devSet) begin
      irqFlagQ <= 1'b1;
      pendCode <= devCode;
    end else if (devAck) begin
      irqFlagQ <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN)
      causeQ <= '0;
    else if (ctl.enterIrq)
      causeQ <= pendCode;
  end

  assert_irq_needs_enable_R2: assert property (@(posedge clk) disable iff (!rstN)
    ctl.enterIrq |-> (curWord.intEn && irqFlagQ));

  assert_entry_masks_R3: assert property (@(posedge clk) disable iff (!rstN)
    (ctl.enterTrap || ctl.enterIrq) |=> (curWord.privMode && !curWord.intEn && !curWord.protEn));

  assert_save_old_R4: assert property (@(posedge clk) disable iff (!rstN)
    ctl.saveOld |=> ((savedWord == $past(curWord)) && saveStrobe));

  assert_flag_sticky_R5: assert property (@(posedge clk) disable iff (!rstN)
    (irqFlagQ && !devAck) |=> irqFlagQ);

  assert_cause_stable_R6: assert property (@(posedge clk) disable iff (!rstN)
    !ctl.enterIrq |=> $stable(causeQ));

  assert_restore_R9: assert property (@(posedge clk) disable iff (!rstN)
    ctl.restore |=> (curWord == $past(savedWord)));
endmodule

// File: rtl/trap_swap_unit.sv
module trap_swap_unit
  import swap_pkg::*;
#(
  parameter int TRAP_W = 4,
  parameter int DEV_W  = 4,
  parameter logic [IC_W-1:0] IRQ_VEC = 16'h0100,
  parameter logic [IC_W-1:0] USER_IC = 16'h4000
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              instrDone,
  input  logic              trapReq,
  input  logic [TRAP_W-1:0] trapCode,
  input  logic              retStrobe,
  input  logic              devSet,
  input  logic [DEV_W-1:0]  devCode,
  input  logic              devAck,
  input  logic              tblWe,
  input  logic [TRAP_W-1:0] tblAddr,
  input  logic [IC_W-1:0]   tblData,
  output logic              curIntEn,
  output logic              curProtEn,
  output logic              curPriv,
  output logic [IC_W-1:0]   curIc,
  output logic              saveEn,
  output logic [WORD_W-1:0] saveWord,
  output logic              irqFlag,
  output logic [DEV_W-1:0]  causeCode
);
  swapCtl_t   ctl;
  stateWord_t curWord;
  stateWord_t savedWord;

  swap_ctrl u_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .instrDone  (instrDone),
    .trapReq    (trapReq),
    .retStrobe  (retStrobe),
    .irqPending (irqFlag),
    .intEnabled (curWord.intEn),
    .ctl        (ctl)
  );

  swap_datapath #(
    .TRAP_W  (TRAP_W),
    .DEV_W   (DEV_W),
    .IRQ_VEC (IRQ_VEC),
    .USER_IC (USER_IC)
  ) u_dp (
    .clk        (clk),
    .rstN       (rstN),
    .ctl        (ctl),
    .trapCode   (trapCode),
    .devSet     (devSet),
    .devCode    (devCode),
    .devAck     (devAck),
    .tblWe      (tblWe),
    .tblAddr    (tblAddr),
    .tblData    (tblData),
    .curWord    (curWord),
    .savedWord  (savedWord),
    .saveStrobe (saveEn),
    .irqFlagQ   (irqFlag),
    .causeQ     (causeCode)
  );

  assign curIntEn  = curWord.intEn;
  assign curProtEn = curWord.protEn;
  assign curPriv   = curWord.privMode;
  assign curIc     = curWord.icount;
  assign saveWord  = savedWord;
endmodule

// File: tb/test_trap_swap_unit.sv
module test_trap_swap_unit;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        instrDone = 0, trapReq = 0, retStrobe = 0, devSet = 0, devAck = 0, tblWe = 0;
  logic [3:0]  trapCode = 0, devCode = 0, tblAddr = 0;
  logic [15:0] tblData = 0;
  logic        curIntEn, curProtEn, curPriv, saveEn, irqFlag;
  logic [15:0] curIc;
  logic [18:0] saveWord;
  logic [3:0]  causeCode;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  localparam logic [18:0] USER_W = {1'b1, 1'b1, 1'b0, 16'h4000};

  always #5 clk = ~clk;

  trap_swap_unit i_trap_swap_unit (
    .clk(clk), .rstN(rstN), .instrDone(instrDone), .trapReq(trapReq), .trapCode(trapCode),
    .retStrobe(retStrobe), .devSet(devSet), .devCode(devCode), .devAck(devAck),
    .tblWe(tblWe), .tblAddr(tblAddr), .tblData(tblData),
    .curIntEn(curIntEn), .curProtEn(curProtEn), .curPriv(curPriv), .curIc(curIc),
    .saveEn(saveEn), .saveWord(saveWord), .irqFlag(irqFlag), .causeCode(causeCode)
  );

  typedef struct packed {
    logic ret; logic dn; logic tr; logic [3:0] tc;
    logic ds; logic [3:0] dc; logic ack;
    logic ePriv; logic eIe; logic eProt; logic [15:0] eIc; logic eFlag; logic [3:0] eCause;
  } vec_t;

  // ret dn tr tc ds dc ack | priv ie prot ic flag cause
  localparam int NV = 20;
  localparam vec_t VECS [NV] = '{
    '{0,1,0,4'd0,0,4'd0,0, 1,0,0,16'h0000,0,4'd0},  // R2 boundary, nothing pending
    '{1,0,0,4'd0,0,4'd0,0, 0,1,1,16'h4000,0,4'd0},  // R9 return to user
    '{0,0,1,4'd3,0,4'd0,0, 0,1,1,16'h4000,0,4'd0},  // R7 trap w/o boundary ignored
    '{0,1,1,4'd3,0,4'd0,0, 1,0,0,16'h0830,0,4'd0},  // R7 trap entry
    '{1,0,0,4'd0,0,4'd0,0, 0,1,1,16'h4000,0,4'd0},  // R9
    '{0,0,0,4'd0,1,4'd5,0, 0,1,1,16'h4000,1,4'd0},  // R5 set flag
    '{0,1,0,4'd0,0,4'd0,0, 1,0,0,16'h0100,1,4'd5},  // R3 R6 irq entry
    '{0,0,0,4'd0,0,4'd0,1, 1,0,0,16'h0100,0,4'd5},  // R5 ack
    '{1,0,0,4'd0,0,4'd0,0, 0,1,1,16'h4000,0,4'd5},  // R9
    '{0,0,0,4'd0,1,4'd9,0, 0,1,1,16'h4000,1,4'd5},  // R5
    '{0,1,1,4'd2,0,4'd0,0, 1,0,0,16'h0820,1,4'd5},  // R8 trap first
    '{1,0,0,4'd0,0,4'd0,0, 0,1,1,16'h4000,1,4'd5},  // R9
    '{0,1,0,4'd0,0,4'd0,0, 1,0,0,16'h0100,1,4'd9},  // R8 pending irq now taken
    '{0,1,0,4'd0,0,4'd0,0, 1,0,0,16'h0100,1,4'd9},  // R2 masked, waits
    '{1,1,0,4'd0,0,4'd0,0, 0,1,1,16'h4000,1,4'd9},  // R9 return beats boundary
    '{0,1,0,4'd0,0,4'd0,0, 1,0,0,16'h0100,1,4'd9},  // R2 re-enabled, taken
    '{0,0,0,4'd0,1,4'd12,1,1,0,0,16'h0100,1,4'd9},  // R5 set wins over ack
    '{0,0,0,4'd0,0,4'd0,1, 1,0,0,16'h0100,0,4'd9},  // R5
    '{1,0,0,4'd0,0,4'd0,0, 0,1,1,16'h4000,0,4'd9},  // R9
    '{0,1,0,4'd0,0,4'd0,0, 0,1,1,16'h4000,0,4'd9}   // R2 no flag, no entry
  };

  task automatic clearIn();
    instrDone = 0; trapReq = 0; retStrobe = 0; devSet = 0; devAck = 0; tblWe = 0;
    trapCode = 0; devCode = 0; tblAddr = 0; tblData = 0;
  endtask

  task automatic tick();
    @(posedge clk); #1;
  endtask

  task automatic check(string req, string what, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic tblWrite(logic [3:0] a, logic [15:0] d);
    tblWe = 1; tblAddr = a; tblData = d;
    tick();
    clearIn();
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    clearIn();
    repeat (3) @(posedge clk);
    #1 rstN = 1;
    // R1 reset state
    check("R1", "state", {curPriv, curIntEn, curProtEn, curIc}, {1'b1, 1'b0, 1'b0, 16'h0000});
    check("R1", "save slot", saveWord, USER_W);
    check("R1", "flag/cause/strobe", {irqFlag, causeCode, saveEn}, 6'b0);

    // R10 table load: entry k = 0x0800 | k<<4
    for (int k = 0; k < 16; k++) tblWrite(4'(k), 16'h0800 | 16'(k << 4));
    check("R10", "load leaves state", {curPriv, curIc}, {1'b1, 16'h0000});

    for (int i = 0; i < NV; i++) begin
      retStrobe = VECS[i].ret; instrDone = VECS[i].dn; trapReq = VECS[i].tr;
      trapCode = VECS[i].tc; devSet = VECS[i].ds; devCode = VECS[i].dc; devAck = VECS[i].ack;
      tick();
      check($sformatf("vec%0d", i), "priv,ie,prot,ic,flag,cause",
            {curPriv, curIntEn, curProtEn, curIc, irqFlag, causeCode},
            {VECS[i].ePriv, VECS[i].eIe, VECS[i].eProt, VECS[i].eIc, VECS[i].eFlag, VECS[i].eCause});
      clearIn();
    end

    // R4 save port on entry from user mode, highest table entry (R7)
    instrDone = 1; trapReq = 1; trapCode = 4'd15;
    tick();
    check("R4", "save word", saveWord, USER_W);
    check("R4", "save strobe high", saveEn, 1'b1);
    check("R7", "entry 15", curIc, 16'h08F0);
    clearIn();
    tick();
    check("R4", "save strobe one cycle", saveEn, 1'b0);
    check("R3", "handler fields", {curPriv, curIntEn, curProtEn}, 3'b100);

    // R10 rewrite entry 0, return, trap 0
    tblWrite(4'd0, 16'hBEEF);
    retStrobe = 1; tick(); clearIn();
    check("R9", "back to user", {curPriv, curIntEn, curProtEn, curIc}, {3'b011, 16'h4000});
    instrDone = 1; trapReq = 1; trapCode = 4'd0; tick(); clearIn();
    check("R10", "rewritten entry", curIc, 16'hBEEF);
    check("R4", "save word again", saveWord, USER_W);

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule